// File: doc/BRIEF.md
# Lane-Local Byte Shift Unit

This unit is a SIMD execution datapath slice. It shifts a 256-bit register value toward the more significant end by a whole number of bytes and fills the vacated low bytes with zeros. Bytes never cross a 128-bit lane boundary. Each lane is shifted on its own, and any count larger than the lane's byte count clears that lane.

A 2-bit mode input selects one of three forms, which differ in the operand they shift and in how they treat the upper lane.

- **Legacy 128-bit:** shifts the old destination value and leaves its upper half untouched.
- **Vector 128-bit:** shifts a separate source and clears the upper half.
- **Vector 256-bit:** shifts both lanes of the source by the same count.

The fourth mode code is an illegal encoding. It raises an illegal-operation flag and does not produce a write.

All outputs are registered and appear one clock after the valid strobe.

Top module: `lane_byte_shift_unit`

## Requirements
- R1: A count c in 0..15 moves every byte of a shifted lane from byte position k to position k+c (8*c bits toward the MSB); positions below c become zero, bytes pushed past position 15 are dropped, and c = 0 passes the lane through unchanged.
- R2: Any count from 16 to 255 (for example 16, 31, 128, 255) turns every shifted lane into all zeros.
- R3: With modeIn = 2'b00 (legacy 128-bit), bits 127:0 of the result are oldDstIn[127:0] shifted, and bits 255:128 equal oldDstIn[255:128] unchanged; srcIn is not used.
- R4: With modeIn = 2'b01 (vector 128-bit), bits 127:0 of the result are srcIn[127:0] shifted, and bits 255:128 are zero.
- R5: With modeIn = 2'b10 (vector 256-bit), srcIn[127:0] and srcIn[255:128] are each shifted by the same count, and no byte moves from the low lane into the high lane.
- R6: With modeIn = 2'b11, the unit sets illegalOut to 1, sets wrEnOut to 0 and loads a zero result.
- R7: The outputs are updated exactly one clock edge after a cycle with validIn high. For a legal mode, wrEnOut is 1 and illegalOut is 0. In a cycle after validIn was low, wrEnOut and illegalOut are 0 and resultOut holds its last value.
- R8: A synchronous active-high reset clears resultOut, wrEnOut and illegalOut to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| validIn | input | 1 | Operation strobe |
| modeIn | input | 2 | 00 legacy 128, 01 vector 128, 10 vector 256, 11 illegal |
| countIn | input | 8 | Unsigned byte shift count |
| srcIn | input | 256 | Separate source operand |
| oldDstIn | input | 256 | Previous destination register value |
| resultOut | output | 256 | Registered shifted result |
| wrEnOut | output | 1 | Registered destination write enable |
| illegalOut | output | 1 | Registered illegal-operation flag |

## Verification
The result, the write enable and the illegal flag are all due on the first rising edge after the cycle in which validIn is high. The bench drives inputs at the falling edge and drops validIn at the next falling edge. It compares all three outputs against its own arithmetic model at that same falling edge, which is half a period after the capturing edge. Hold behaviour is checked by idling one cycle with changed inputs and confirming that the result still holds the earlier value and that both flags are low. The reset check follows the same one-edge rule.

// File: rtl/lbs_pkg.sv
package lbs_pkg;

  typedef enum logic [1:0] {
    MODE_LEG128 = 2'b00,
    MODE_VEC128 = 2'b01,
    MODE_VEC256 = 2'b10,
    MODE_BAD    = 2'b11
  } modeT;

  typedef enum logic [1:0] {
    UP_KEEP  = 2'b00,
    UP_ZERO  = 2'b01,
    UP_SHIFT = 2'b10
  } upperPolicyT;

  typedef struct packed {
    logic        load;
    logic        selOldDst;
    upperPolicyT upper;
    logic        kill;
  } dpCtrlT;

endpackage

// File: rtl/lbs_lane_shifter.sv
module lbs_lane_shifter #(
  parameter int LANE_BYTES = 16,
  parameter int BYTE_W     = 8,
  parameter int CNT_W      = 8
) (
  input  logic [LANE_BYTES*BYTE_W-1:0] laneIn,
  input  logic [CNT_W-1:0]             count,
  output logic [LANE_BYTES*BYTE_W-1:0] laneOut
);
  localparam int LANE_W = LANE_BYTES * BYTE_W;
  localparam int STAGES = $clog2(LANE_BYTES);

  logic [LANE_W-1:0] stg [STAGES+1];
  logic saturate;

  assign stg[0] = laneIn;

  // Logarithmic shifter: stage i moves by 2**i bytes when count bit i is set.
  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    localparam int SHIFT_BITS = BYTE_W * (1 << i);
    assign stg[i+1] = count[i] ? (stg[i] << SHIFT_BITS) : stg[i];
  end

  // Any count at or above LANE_BYTES empties the lane.
  assign saturate = |count[CNT_W-1:STAGES];
  assign laneOut  = saturate ? '0 : stg[STAGES];

endmodule

// File: rtl/lbs_control.sv
module lbs_control
  import lbs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       validIn,
  input  logic [1:0] modeIn,
  output dpCtrlT     dpCtrl,
  output logic       wrEnOut,
  output logic       illegalOut
);
  modeT mode;
  assign mode = modeT'(modeIn);

  always_comb begin
    dpCtrl.load      = validIn;
    dpCtrl.selOldDst = 1'b0;
    dpCtrl.upper     = UP_ZERO;
    dpCtrl.kill      = 1'b0;
    unique case (mode)
      MODE_LEG128: begin dpCtrl.selOldDst = 1'b1; dpCtrl.upper = UP_KEEP; end
      MODE_VEC128: dpCtrl.upper = UP_ZERO;
      MODE_VEC256: dpCtrl.upper = UP_SHIFT;
      MODE_BAD:    dpCtrl.kill  = 1'b1;
      default:     dpCtrl.kill  = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrEnOut    <= 1'b0;
      illegalOut <= 1'b0;
    end else begin
      wrEnOut    <= validIn && (mode != MODE_BAD);
      illegalOut <= validIn && (mode == MODE_BAD);
    end
  end

  assert_illegal_no_write_R6: assert property (@(posedge clk) disable iff (rst)
    illegalOut |-> !wrEnOut);
  assert_flags_follow_valid_R7: assert property (@(posedge clk) disable iff (rst)
    (wrEnOut || illegalOut) |-> $past(validIn));
  assert_bad_mode_flagged_R6: assert property (@(posedge clk) disable iff (rst)
    (validIn && modeIn == 2'b11) |=> (illegalOut && !wrEnOut));

endmodule

// File: rtl/lbs_datapath.sv
module lbs_datapath
  import lbs_pkg::*;
#(
  parameter int LANE_BYTES = 16,
  parameter int NUM_LANES  = 2,
  parameter int BYTE_W     = 8,
  parameter int CNT_W      = 8
) (
  input  logic                                clk,
  input  logic                                rst,
  input  dpCtrlT                              dpCtrl,
  input  logic [CNT_W-1:0]                    count,
  input  logic [NUM_LANES*LANE_BYTES*BYTE_W-1:0] src,
  input  logic [NUM_LANES*LANE_BYTES*BYTE_W-1:0] oldDst,
  output logic [NUM_LANES*LANE_BYTES*BYTE_W-1:0] result
);
  localparam int LANE_W = LANE_BYTES * BYTE_W;
  localparam int DATA_W = NUM_LANES * LANE_W;
  localparam int STAGES = $clog2(LANE_BYTES);

  logic [DATA_W-1:0] nextResult;

  for (genvar ln = 0; ln < NUM_LANES; ln++) begin : g_lane
    logic [LANE_W-1:0] laneSrc;
    logic [LANE_W-1:0] laneShifted;

    if (ln == 0) begin : g_low
      assign laneSrc = dpCtrl.selOldDst ? oldDst[LANE_W-1:0] : src[LANE_W-1:0];
    end else begin : g_high
      assign laneSrc = src[ln*LANE_W +: LANE_W];
    end

    lbs_lane_shifter #(
      .LANE_BYTES(LANE_BYTES),
      .BYTE_W    (BYTE_W),
      .CNT_W     (CNT_W)
    ) shifter_i (
      .laneIn (laneSrc),
      .count  (count),
      .laneOut(laneShifted)
    );

    if (ln == 0) begin : g_low_sel
      always_comb begin
        nextResult[LANE_W-1:0] = dpCtrl.kill ? '0 : laneShifted;
      end
    end else begin : g_high_sel
      always_comb begin
        if (dpCtrl.kill) begin
          nextResult[ln*LANE_W +: LANE_W] = '0;
        end else begin
          unique case (dpCtrl.upper)
            UP_KEEP:  nextResult[ln*LANE_W +: LANE_W] = oldDst[ln*LANE_W +: LANE_W];
            UP_SHIFT: nextResult[ln*LANE_W +: LANE_W] = laneShifted;
            default:  nextResult[ln*LANE_W +: LANE_W] = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
    end else if (dpCtrl.load) begin
      result <= nextResult;
    end
  end

  assert_upper_zeroed_R4: assert property (@(posedge clk) disable iff (rst)
    (dpCtrl.load && !dpCtrl.kill && dpCtrl.upper == UP_ZERO)
      |=> (result[DATA_W-1:LANE_W] == '0));
  assert_upper_kept_R3: assert property (@(posedge clk) disable iff (rst)
    (dpCtrl.load && !dpCtrl.kill && dpCtrl.upper == UP_KEEP)
      |=> (result[DATA_W-1:LANE_W] == $past(oldDst[DATA_W-1:LANE_W])));
  assert_saturate_clear_R2: assert property (@(posedge clk) disable iff (rst)
    (dpCtrl.load && (|count[CNT_W-1:STAGES]) && dpCtrl.upper == UP_SHIFT)
      |=> (result == '0));
  assert_zero_count_pass_R1: assert property (@(posedge clk) disable iff (rst)
    (dpCtrl.load && !dpCtrl.kill && count == '0 && dpCtrl.upper == UP_SHIFT)
      |=> (result == $past(src)));
  assert_hold_when_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !dpCtrl.load |=> $stable(result));

endmodule

// File: rtl/lane_byte_shift_unit.sv
module lane_byte_shift_unit
  import lbs_pkg::*;
#(
  parameter int LANE_BYTES = 16,
  parameter int NUM_LANES  = 2,
  parameter int BYTE_W     = 8,
  parameter int CNT_W      = 8
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   validIn,
  input  logic [1:0]                             modeIn,
  input  logic [CNT_W-1:0]                       countIn,
  input  logic [NUM_LANES*LANE_BYTES*BYTE_W-1:0] srcIn,
  input  logic [NUM_LANES*LANE_BYTES*BYTE_W-1:0] oldDstIn,
  output logic [NUM_LANES*LANE_BYTES*BYTE_W-1:0] resultOut,
  output logic                                   wrEnOut,
  output logic                                   illegalOut
);
  dpCtrlT dpCtrl;

  lbs_control control_i (
    .clk       (clk),
    .rst       (rst),
    .validIn   (validIn),
    .modeIn    (modeIn),
    .dpCtrl    (dpCtrl),
    .wrEnOut   (wrEnOut),
    .illegalOut(illegalOut)
  );

  lbs_datapath #(
    .LANE_BYTES(LANE_BYTES),
    .NUM_LANES (NUM_LANES),
    .BYTE_W    (BYTE_W),
    .CNT_W     (CNT_W)
  ) datapath_i (
    .clk   (clk),
    .rst   (rst),
    .dpCtrl(dpCtrl),
    .count (countIn),
    .src   (srcIn),
    .oldDst(oldDstIn),
    .result(resultOut)
  );

  assert_illegal_zero_result_R6: assert property (@(posedge clk) disable iff (rst)
    illegalOut |-> (resultOut == '0));

endmodule

// File: tb/lane_byte_shift_unit_tb.sv
module lane_byte_shift_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst;
  logic         validIn;
  logic [1:0]   modeIn;
  logic [7:0]   countIn;
  logic [255:0] srcIn;
  logic [255:0] oldDstIn;
  logic [255:0] resultOut;
  logic         wrEnOut;
  logic         illegalOut;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_byte_shift_unit dut_i (
    .clk       (clk),
    .rst       (rst),
    .validIn   (validIn),
    .modeIn    (modeIn),
    .countIn   (countIn),
    .srcIn     (srcIn),
    .oldDstIn  (oldDstIn),
    .resultOut (resultOut),
    .wrEnOut   (wrEnOut),
    .illegalOut(illegalOut)
  );

  function automatic logic [127:0] laneShl(input logic [127:0] v, input int c);
    logic [127:0] r;
    r = '0;
    if (c <= 15) begin
      for (int k = 0; k + c < 16; k++) r[(k+c)*8 +: 8] = v[k*8 +: 8];
    end
    return r;
  endfunction

  function automatic logic [255:0] model(input logic [1:0] m, input int c,
                                         input logic [255:0] s, input logic [255:0] d);
    case (m)
      2'b00:   return {d[255:128], laneShl(d[127:0], c)};
      2'b01:   return {128'h0, laneShl(s[127:0], c)};
      2'b10:   return {laneShl(s[255:128], c), laneShl(s[127:0], c)};
      default: return '0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [255:0] expRes,
                       input logic expWr, input logic expIll);
    checks++;
    if (resultOut !== expRes || wrEnOut !== expWr || illegalOut !== expIll) begin
      errors++;
      $display("FAIL %s: result=%h wrEn=%b illegal=%b expected result=%h wrEn=%b illegal=%b",
               tag, resultOut, wrEnOut, illegalOut, expRes, expWr, expIll);
    end
  endtask

  task automatic runOp(input string tag, input logic [1:0] m, input int c,
                       input logic [255:0] s, input logic [255:0] d);
    @(negedge clk);
    validIn = 1'b1; modeIn = m; countIn = 8'(c); srcIn = s; oldDstIn = d;
    @(negedge clk);
    validIn = 1'b0;
    check(tag, model(m, c, s, d), m != 2'b11, m == 2'b11);
  endtask

  function automatic logic [255:0] pattern(input int seed);
    logic [255:0] p;
    for (int k = 0; k < 32; k++) p[k*8 +: 8] = 8'((k * 37 + seed * 11 + 1) & 8'hFF);
    return p;
  endfunction

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete, actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [255:0] lastRes;
    string tag;
    rst = 1'b1; validIn = 1'b0; modeIn = 2'b00; countIn = '0;
    srcIn = '0; oldDstIn = '0;
    repeat (3) @(negedge clk);
    check("R8 reset state", '0, 1'b0, 1'b0);
    rst = 1'b0;

    // R1: zero count passes through, small counts move bytes
    runOp("R1 count0 vec256", 2'b10, 0, pattern(1), pattern(2));
    runOp("R1 count1 vec256", 2'b10, 1, {32{8'hFF}}, '0);
    runOp("R1 count15 vec128", 2'b01, 15, pattern(3), pattern(4));
    // R2: boundary saturation
    runOp("R2 count16", 2'b10, 16, {32{8'hFF}}, pattern(5));
    runOp("R2 count255", 2'b10, 255, {32{8'hFF}}, pattern(5));

    // Exhaustive count sweep over all modes and two data patterns
    for (int pat = 0; pat < 2; pat++) begin
      for (int m = 0; m < 4; m++) begin
        for (int c = 0; c < 256; c++) begin
          if (m == 3)       tag = "R6 illegal mode";
          else if (c > 15)  tag = "R2 saturated count";
          else if (m == 0)  tag = "R3 legacy";
          else if (m == 1)  tag = "R4 vector128";
          else              tag = "R5 vector256";
          runOp(tag, 2'(m), c, pattern(pat * 7 + m), pattern(pat * 7 + m + 50));
        end
      end
    end

    // R5: low-lane top byte must not enter high lane
    runOp("R5 no lane crossing", 2'b10, 1, {128'h0, 8'hAB, 120'h0}, '0);
    // R3: source ignored in legacy mode
    runOp("R3 src ignored", 2'b00, 3, {32{8'h5A}}, pattern(9));

    // R7: idle cycle holds result and drops flags
    runOp("R7 before idle", 2'b10, 2, pattern(11), pattern(12));
    lastRes = resultOut;
    @(negedge clk);
    srcIn = pattern(13); oldDstIn = pattern(14); modeIn = 2'b11; countIn = 8'd4;
    @(negedge clk);
    check("R7 idle hold", lastRes, 1'b0, 1'b0);

    // R8: reset mid-run
    runOp("R7 legal write", 2'b01, 5, pattern(15), pattern(16));
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R8 reset clears", '0, 1'b0, 1'b0);
    rst = 1'b0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule